// File: doc/BRIEF.md
# Two-Word Burst Split-Port SRAM

This block is an on-chip memory with one shared address bus, an independent write data bus and an independent read data bus. Every access moves a pair of words: the word at the latched address A and the word at A+1, wrapping at the top of the array. In a single command slot a read and a write can both be accepted. They then use the same address, and the read sees the contents from before that write.

The double-data-rate timing is modelled on one internal clock that runs at twice the command rate. A beat index alternates on each running edge. Commands are taken only on the even beat, which stands for the rising edge of the command clock. A write takes its first word on that edge and its second word on the next one. Read words leave on the output bus 1.5 command cycles after the command. A fallback latency mode shortens this to one command cycle.

Byte lanes are masked per beat. The high-impedance read bus is represented by an output-enable flag together with a zeroed data bus. Holding `run` low stands for a stopped clock: memory, beat index and outputs all freeze.

Top module: `burst_pair_sram`

## Requirements
- R1: After reset `beat` is 0. It inverts on every `clk` edge where `run` is high. Commands are sampled only on running edges where `beat` is 0 beforehand (the command slot), and selects on the other edges are ignored.
- R2: With `wr_sel_n` low in a command slot, `wr_data` of that edge is stored at `addr` (A). `wr_data` of the next running edge is stored at A+1, which wraps from the top address to 0.
- R3: `wr_mask_n` bit i covers byte lane i, which is `wr_data[8i+7:8i]`. It is sampled with each write beat. A low bit writes the lane, and a high bit leaves the stored byte unchanged.
- R4: With `short_lat` low, a read accepted in slot edge k puts word A on `rd_data` after running edge k+3 and word A+1 after running edge k+4.
- R5: With `short_lat` high, the same words appear after running edges k+2 and k+3.
- R6: A read and a write in the same slot are both carried out. The read returns the contents from before that write.
- R7: `rd_oe` is high exactly while a read word is on `rd_data`. While `rd_oe` is low, `rd_data` is all zero.
- R8: `rd_strobe` is 1 during the first word of a read pair and 0 during the second word and when idle. The first word is always followed by the second.
- R9: A slot with both selects high stores nothing and starts no read output.
- R10: While `run` is low, memory, `beat`, `rd_data`, `rd_oe` and `rd_strobe` keep their values, whatever the other inputs do.
- R11: While `rst_n` is low, `rd_oe`, `rd_strobe`, `rd_data` and `beat` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; each edge is one beat |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | High while the command clock runs; low freezes all state |
| short_lat | input | 1 | Fallback mode: read latency of one command cycle |
| rd_sel_n | input | 1 | Active-low read select |
| wr_sel_n | input | 1 | Active-low write select |
| addr | input | AW (6) | Burst base address, shared by read and write |
| wr_data | input | NB*BW (16) | Write word for the current beat |
| wr_mask_n | input | NB (2) | Active-low byte-lane write mask for the current beat |
| rd_data | output | NB*BW (16) | Read word, zero when idle |
| rd_oe | output | 1 | High while a read word is driven |
| rd_strobe | output | 1 | High on the first word of a read pair |
| beat | output | 1 | Beat index; 0 before a command slot |

## Verification
Each running edge is given an index counted from reset release, and edges with `run` low are left out of the count. The bench schedules every read result at slot edge plus 3 and plus 4 (plus 2 and plus 3 in the fallback mode). It samples on the falling edge after that edge, so every register between the select input and the output is counted. Writes land in the bench's memory model on the slot edge and on the next running edge. A read in the same slot takes its expected words before the write is applied. On a frozen edge the expected outputs are the values sampled one edge earlier.

// File: rtl/burst_pair_pkg.sv
package burst_pair_pkg;

  // Position inside one command-clock period.
  typedef enum logic {
    BEAT_K  = 1'b0,   // command slot, first data beat
    BEAT_KN = 1'b1    // complementary edge, second data beat
  } beat_e;

  // Decoded command of one slot.
  typedef struct packed {
    logic rd;
    logic wr;
  } cmd_t;

endpackage

// File: rtl/bp_reset_sync.sv
module bp_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bp_cmd_ctl.sv
module bp_cmd_ctl
  import burst_pair_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] addr,
  output beat_e         beat,
  output logic          rd_go,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr
);

  localparam logic [AW-1:0] ADDR_STEP = {{(AW-1){1'b0}}, 1'b1};

  beat_e         beat_q, beat_d;
  logic          wr_pend_q, wr_pend_d;
  logic [AW-1:0] wr_base_q, wr_base_d;
  cmd_t          cmd;

  always_comb begin
    cmd.rd = ~rd_sel_n;
    cmd.wr = ~wr_sel_n;
  end

  // Next state and beat strobes.
  always_comb begin
    beat_d    = beat_q;
    wr_pend_d = wr_pend_q;
    wr_base_d = wr_base_q;
    rd_go     = 1'b0;
    wr_en     = 1'b0;
    wr_addr   = addr;
    if (run) begin
      beat_d = (beat_q == BEAT_K) ? BEAT_KN : BEAT_K;
      if (beat_q == BEAT_K) begin
        rd_go     = cmd.rd;
        wr_en     = cmd.wr;
        wr_addr   = addr;
        wr_pend_d = cmd.wr;
        if (cmd.wr) begin
          wr_base_d = addr;
        end
      end else begin
        wr_en     = wr_pend_q;
        wr_addr   = wr_base_q + ADDR_STEP;
        wr_pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q    <= BEAT_K;
      wr_pend_q <= 1'b0;
      wr_base_q <= '0;
    end else if (run) begin
      beat_q    <= beat_d;
      wr_pend_q <= wr_pend_d;
      wr_base_q <= wr_base_d;
    end
  end

  assign beat = beat_q;

endmodule

// File: rtl/bp_store.sv
module bp_store #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [NB*BW-1:0] wr_data,
  input  logic [NB-1:0]   wr_mask_n,
  input  logic [AW-1:0]   rd_addr,
  output logic [NB*BW-1:0] rd_word0,
  output logic [NB*BW-1:0] rd_word1
);

  localparam int DEPTH = 1 << AW;
  localparam int DW    = NB * BW;
  localparam logic [AW-1:0] ADDR_STEP = {{(AW-1){1'b0}}, 1'b1};

  logic [DW-1:0] mem_q [DEPTH];
  logic [NB-1:0] lane_we;
  logic [AW-1:0] rd_addr_nxt;

  // One enable per byte lane.
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_we[b] = wr_en & ~wr_mask_n[b];
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (lane_we[b]) begin
        mem_q[wr_addr][b*BW +: BW] <= wr_data[b*BW +: BW];
      end
    end
  end

  // Both words of the pair are read at the slot edge.
  assign rd_addr_nxt = rd_addr + ADDR_STEP;
  assign rd_word0    = mem_q[rd_addr];
  assign rd_word1    = mem_q[rd_addr_nxt];

endmodule

// File: rtl/bp_read_pipe.sv
module bp_read_pipe
  import burst_pair_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  beat_e         beat,
  input  logic          short_lat,
  input  logic          rd_go,
  input  logic [DW-1:0] word0,
  input  logic [DW-1:0] word1,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe,
  output logic          rd_strobe
);

  // Stage 1: captured at the slot edge.
  logic          v1_q, v1_d;
  logic [DW-1:0] a1_q, a1_d, b1_q, b1_d;
  // Stage 2: moved on the complementary edge.
  logic          v2_q, v2_d;
  logic [DW-1:0] a2_q, a2_d, b2_q, b2_d;
  // Second-word hold and output registers.
  logic          hv_q, hv_d;
  logic [DW-1:0] hd_q, hd_d;
  logic          ov_q, ov_d, os_q, os_d;
  logic [DW-1:0] od_q, od_d;
  logic          launch;

  always_comb begin
    launch = short_lat ? (beat == BEAT_K) : (beat == BEAT_KN);
  end

  always_comb begin
    v1_d = v1_q;  a1_d = a1_q;  b1_d = b1_q;
    v2_d = v2_q;  a2_d = a2_q;  b2_d = b2_q;
    hv_d = hv_q;  hd_d = hd_q;
    ov_d = ov_q;  os_d = os_q;  od_d = od_q;
    if (run) begin
      if (beat == BEAT_K) begin
        v1_d = rd_go;
        if (rd_go) begin
          a1_d = word0;
          b1_d = word1;
        end
      end else begin
        v2_d = v1_q;
        a2_d = a1_q;
        b2_d = b1_q;
      end
      if (launch) begin
        ov_d = v2_q;
        os_d = v2_q;
        od_d = v2_q ? a2_q : '0;
        hv_d = v2_q;
        hd_d = b2_q;
      end else begin
        ov_d = hv_q;
        os_d = 1'b0;
        od_d = hv_q ? hd_q : '0;
        hv_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;  a1_q <= '0;  b1_q <= '0;
      v2_q <= 1'b0;  a2_q <= '0;  b2_q <= '0;
      hv_q <= 1'b0;  hd_q <= '0;
      ov_q <= 1'b0;  os_q <= 1'b0;  od_q <= '0;
    end else if (run) begin
      v1_q <= v1_d;  a1_q <= a1_d;  b1_q <= b1_d;
      v2_q <= v2_d;  a2_q <= a2_d;  b2_q <= b2_d;
      hv_q <= hv_d;  hd_q <= hd_d;
      ov_q <= ov_d;  os_q <= os_d;  od_q <= od_d;
    end
  end

  assign rd_data   = od_q;
  assign rd_oe     = ov_q;
  assign rd_strobe = os_q;

endmodule

// File: rtl/burst_pair_sram.sv
module burst_pair_sram
  import burst_pair_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             short_lat,
  input  logic             rd_sel_n,
  input  logic             wr_sel_n,
  input  logic [AW-1:0]    addr,
  input  logic [NB*BW-1:0] wr_data,
  input  logic [NB-1:0]    wr_mask_n,
  output logic [NB*BW-1:0] rd_data,
  output logic             rd_oe,
  output logic             rd_strobe,
  output logic             beat
);

  localparam int DW = NB * BW;

  logic          rst_sync_n;
  beat_e         beat_s;
  logic          rd_go;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] word0, word1;

  bp_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bp_cmd_ctl #(.AW(AW)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .rd_sel_n (rd_sel_n),
    .wr_sel_n (wr_sel_n),
    .addr     (addr),
    .beat     (beat_s),
    .rd_go    (rd_go),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr)
  );

  bp_store #(.AW(AW), .NB(NB), .BW(BW)) u_store (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_mask_n (wr_mask_n),
    .rd_addr   (addr),
    .rd_word0  (word0),
    .rd_word1  (word1)
  );

  bp_read_pipe #(.DW(DW)) u_rdp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (run),
    .beat      (beat_s),
    .short_lat (short_lat),
    .rd_go     (rd_go),
    .word0     (word0),
    .word1     (word1),
    .rd_data   (rd_data),
    .rd_oe     (rd_oe),
    .rd_strobe (rd_strobe)
  );

  assign beat = beat_s;

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          short_lat,
  input logic          beat,
  input logic [DW-1:0] rd_data,
  input logic          rd_oe,
  input logic          rd_strobe
);

  AST_BEAT_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rst_n) |=> (beat != $past(beat)));  // R1

  AST_FIRST_WORD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && rd_strobe) |-> (beat == short_lat));  // R4

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rd_data == '0 && !rd_strobe));  // R7

  AST_PAIR_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rst_n && rd_oe && rd_strobe) |=> (rd_oe && !rd_strobe));  // R8

  AST_FROZEN_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && rst_n) |=> ($stable(rd_data) && $stable(rd_oe) &&
                         $stable(rd_strobe) && $stable(beat)));  // R10

endmodule

bind burst_pair_sram bp_checker #(.DW(NB*BW)) u_bp_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .run       (run),
  .short_lat (short_lat),
  .beat      (beat),
  .rd_data   (rd_data),
  .rd_oe     (rd_oe),
  .rd_strobe (rd_strobe)
);

// File: tb/tb_burst_pair_sram.sv
module tb_burst_pair_sram;

  localparam int AW    = 6;
  localparam int NB    = 2;
  localparam int BW    = 8;
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n, run, short_lat, rd_sel_n, wr_sel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data, rd_data;
  logic [NB-1:0] wr_mask_n;
  logic          rd_oe, rd_strobe, beat;

  always #4 clk = ~clk;  // 125 MHz

  burst_pair_sram #(.AW(AW), .NB(NB), .BW(BW)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .short_lat(short_lat),
    .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n), .addr(addr),
    .wr_data(wr_data), .wr_mask_n(wr_mask_n),
    .rd_data(rd_data), .rd_oe(rd_oe), .rd_strobe(rd_strobe), .beat(beat)
  );

  int vectors = 0;
  int fails   = 0;

  logic [DW-1:0] model [DEPTH];
  logic          ev [8];
  logic [DW-1:0] ed [8];
  logic          es [8];

  int            k = 0;
  int            idx_prev = 0;
  bit            prev_run = 0, have_prev = 0;
  bit            wpend = 0;
  logic [AW-1:0] wbase = '0;
  logic [DW-1:0] last_d;
  logic          last_oe, last_s, last_beat;
  string         data_tag = "R4";

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o,
                                          input logic [DW-1:0] n,
                                          input logic [NB-1:0] m_n);
    logic [DW-1:0] r = o;
    for (int b = 0; b < NB; b++) begin
      if (!m_n[b]) r[b*BW +: BW] = n[b*BW +: BW];
    end
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at edge %0d: actual %h expected %h",
               req, what, idx_prev, act, exp);
    end
  endtask

  task automatic check_out();
    if (prev_run) begin
      int s = idx_prev % 8;
      chk("R7", "rd_oe", DW'(rd_oe), DW'(ev[s]));
      chk(data_tag, "rd_data", rd_data, ed[s]);
      chk("R8", "rd_strobe", DW'(rd_strobe), DW'(es[s]));
      chk("R1", "beat", DW'(beat), DW'((idx_prev + 1) % 2));
      ev[s] = 1'b0; ed[s] = '0; es[s] = 1'b0;
    end else begin
      chk("R10", "held rd_data", rd_data, last_d);
      chk("R10", "held rd_oe", DW'(rd_oe), DW'(last_oe));
      chk("R10", "held rd_strobe", DW'(rd_strobe), DW'(last_s));
      chk("R10", "held beat", DW'(beat), DW'(last_beat));
    end
    last_d = rd_data; last_oe = rd_oe; last_s = rd_strobe; last_beat = beat;
  endtask

  // One clk edge: check the previous edge, drive this one, update the model.
  task automatic step(input bit run_v, input bit rd_n, input bit wr_n,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [NB-1:0] m);
    logic [AW-1:0] na;
    @(negedge clk);
    if (have_prev) check_out();
    run = run_v; rd_sel_n = rd_n; wr_sel_n = wr_n;
    addr = a; wr_data = d; wr_mask_n = m;
    if (run_v) begin
      if (k % 2 == 0) begin
        na = a + 1'b1;
        if (!rd_n) begin
          int lat = short_lat ? 2 : 3;
          ev[(k+lat)%8]   = 1'b1; ed[(k+lat)%8]   = model[a];  es[(k+lat)%8]   = 1'b1;
          ev[(k+lat+1)%8] = 1'b1; ed[(k+lat+1)%8] = model[na]; es[(k+lat+1)%8] = 1'b0;
        end
        if (!wr_n) begin
          model[a] = merge(model[a], d, m);
          wpend = 1'b1;
          wbase = a;
        end else begin
          wpend = 1'b0;
        end
      end else begin
        if (wpend) begin
          na = wbase + 1'b1;
          model[na] = merge(model[na], d, m);
        end
        wpend = 1'b0;
      end
      idx_prev = k;
      k++;
    end
    prev_run  = run_v;
    have_prev = 1'b1;
  endtask

  task automatic stall(input int n);
    for (int i = 0; i < n; i++) begin
      // R10: selects and data toggle while frozen
      step(1'b0, 1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom),
           NB'($urandom));
    end
  endtask

  task automatic kcyc(input bit rd_n, input bit wr_n, input logic [AW-1:0] a,
                      input logic [DW-1:0] d0, input logic [NB-1:0] m0,
                      input logic [DW-1:0] d1, input logic [NB-1:0] m1,
                      input int stalls);
    step(1'b1, rd_n, wr_n, a, d0, m0);
    stall(stalls);
    // R1: selects on the second beat must be ignored
    step(1'b1, 1'($urandom), 1'($urandom), AW'($urandom), d1, m1);
  endtask

  task automatic drain();
    for (int i = 0; i < 3; i++) kcyc(1'b1, 1'b1, '0, '0, '1, '0, '1, 0);
  endtask

  task automatic rand_phase(input int n);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] a = ($urandom % 2 == 0) ? AW'($urandom % 8) : AW'($urandom);
      int st = ($urandom % 8 == 0) ? 1 + int'($urandom % 2) : 0;
      kcyc(1'($urandom), 1'($urandom), a, DW'($urandom), NB'($urandom),
           DW'($urandom), NB'($urandom), st);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 8; i++) begin ev[i] = 1'b0; ed[i] = '0; es[i] = 1'b0; end
    run = 1'b0; short_lat = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    addr = '0; wr_data = '0; wr_mask_n = '1;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "reset rd_oe", DW'(rd_oe), '0);
    chk("R11", "reset rd_data", rd_data, '0);
    chk("R11", "reset rd_strobe", DW'(rd_strobe), '0);
    chk("R11", "reset beat", DW'(beat), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    last_d = rd_data; last_oe = rd_oe; last_s = rd_strobe; last_beat = beat;

    // R2: fill every word with full writes
    data_tag = "R2";
    for (int a = 0; a < DEPTH; a += 2) begin
      kcyc(1'b1, 1'b0, AW'(a), DW'($urandom), '0, DW'($urandom), '0, 0);
    end
    // R3: lane masks, byte 0 on first beat, byte 1 on second
    data_tag = "R3";
    kcyc(1'b1, 1'b0, AW'(5), 16'hA1B2, 2'b10, 16'hC3D4, 2'b01, 0);
    kcyc(1'b0, 1'b1, AW'(5), '0, '1, '0, '1, 0);
    drain();
    // R2: pair at the top address wraps to address 0
    data_tag = "R2";
    kcyc(1'b1, 1'b0, AW'(DEPTH-1), 16'h1357, '0, 16'h2468, '0, 1);
    kcyc(1'b0, 1'b1, AW'(DEPTH-1), '0, '1, '0, '1, 0);
    drain();
    // R6: read and write in one slot, then read the new contents
    data_tag = "R6";
    kcyc(1'b0, 1'b0, AW'(10), 16'hBEEF, '0, 16'hCAFE, '0, 0);
    kcyc(1'b0, 1'b1, AW'(10), '0, '1, '0, '1, 0);
    drain();
    // R9: no-op slot with live data and open masks
    data_tag = "R9";
    kcyc(1'b1, 1'b1, AW'(20), 16'hDEAD, '0, 16'hF00D, '0, 0);
    kcyc(1'b0, 1'b1, AW'(20), '0, '1, '0, '1, 0);
    drain();
    // R10: clock stopped in the middle of a read pair
    data_tag = "R10";
    kcyc(1'b0, 1'b1, AW'(30), '0, '1, '0, '1, 3);
    step(1'b1, 1'b1, 1'b1, '0, '0, '1);
    stall(2);
    step(1'b1, 1'b1, 1'b1, '0, '0, '1);
    stall(2);
    drain();
    // R4: back-to-back reads, then mixed random traffic
    data_tag = "R4";
    for (int i = 0; i < 4; i++) kcyc(1'b0, 1'b1, AW'(2*i), '0, '1, '0, '1, 0);
    rand_phase(1200);
    drain();
    // R5: fallback latency
    short_lat = 1'b1;
    data_tag = "R5";
    kcyc(1'b0, 1'b1, AW'(3), '0, '1, '0, '1, 0);
    kcyc(1'b0, 1'b0, AW'(3), 16'h7777, '0, 16'h8888, '0, 0);
    rand_phase(1200);
    drain();
    step(1'b0, 1'b1, 1'b1, '0, '0, '1);
    @(negedge clk);
    check_out();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule